// File: doc/BRIEF.md
# Compressed Instruction Segment Decoder

This block rebuilds a full 32-bit instruction from a compressed word of one fixed layout. In that layout the upper halfword travels inside the compressed word as raw bypass bits, which may be shorter than 16 bits. The lower halfword is held in a vocabulary table and is reached through a short pointer. Inside the compressed word the pointer field comes first and the bypass field second. The decoder swaps them back, so the bypass bits form the upper halfword and the vocabulary entry forms the lower one.

Two vocabulary banks sit inside the block as register arrays with a synchronous read. They are loaded through a plain write port. A small set of configuration registers holds one base address per bank, the pointer width, the bypass length code and the bank select. Software writes these registers while no words are in flight. Compressed words arrive on a valid/ready input and leave on a valid/ready output.

The block has one output register stage and no skid buffer. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new word is accepted. A word whose length code is not legal is still consumed. It produces no output and pulses `err_pulse` instead.

Top module: `cinstr_expand`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `err_pulse` are 0 and `in_ready` is 1. The configuration resets to both bases 0, pointer width 2, length code 0xE and bank 0.
- R2: The top 4 bits [31:28] of a compressed word are the class field and are not examined. The pointer occupies the next W bits, MSB first, starting at bit 27. W comes from config register 2 bits [3:0]. Values below 2 act as 2 and values above 9 act as 9. Bits below the bypass field are ignored.
- R3: The lower output halfword is the vocabulary word at address (base of the selected bank + pointer) mod 2^VOC_AW. Config register 0 holds the base of bank 0 and register 1 holds the base of bank 1. A vocabulary write stores `voc_wdata` at `voc_addr` of bank `voc_bank`.
- R4: Config register 2 bit [8] selects the bank: 0 selects bank 0 and 1 selects bank 1. Writes to config address 3 change nothing.
- R5: The bypass field starts right after the pointer. Length code (config register 2 bits [7:4]) 0xE takes 16 bypass bits and copies them unchanged into bits [31:16].
- R6: Code 0xD takes 15 bypass bits and code 0xC takes 10 bypass bits. Each is sign-extended to form the upper halfword.
- R7: Code 0xB takes no bypass bits, and the upper halfword is zero.
- R8: Any other length code makes an accepted word pulse `err_pulse` in the next cycle, with `out_valid` low. The word is consumed.
- R9: A legal word accepted at a clock edge appears with `out_valid` high right after the next edge, so the latency is one cycle.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the next cycle still has `out_valid` high and the same `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Config register: 0 base bank 0, 1 base bank 1, 2 mode |
| cfg_wdata | input | 16 | Configuration write data |
| voc_we | input | 1 | Vocabulary write strobe |
| voc_bank | input | 1 | Vocabulary bank to write |
| voc_addr | input | VOC_AW | Vocabulary write address |
| voc_wdata | input | 16 | Vocabulary write data |
| in_valid | input | 1 | Compressed word offered |
| in_ready | output | 1 | Block accepts the offered word |
| in_data | input | 32 | Compressed word |
| out_valid | output | 1 | Expanded instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | 32 | Expanded instruction |
| err_pulse | output | 1 | Illegal length code on the last accepted word |

## Verification
Both the expanded instruction and the error pulse are due exactly one edge after the word is accepted. `in_ready` is combinational, so it reflects `out_ready` within the same cycle. The reference model in the bench advances at each rising edge from the same handshake and write ports. The bench compares `in_ready`, `out_valid`, `err_pulse` and `out_data` at every falling edge, so each comparison falls half a period after the edge that produced the value. Stalls under random `out_ready` test the hold rule cycle by cycle.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int INSTR_W = 32;
  localparam int CLASS_W = 4;
  localparam int HALF_W  = 16;
  localparam int BODY_W  = INSTR_W - CLASS_W;
  localparam int PTR_MIN = 2;
  localparam int PTR_MAX = 9;

  typedef enum logic [3:0] {
    LEN_NONE = 4'hB,
    LEN_10   = 4'hC,
    LEN_15   = 4'hD,
    LEN_FULL = 4'hE
  } len_code_e;

  typedef enum logic [1:0] {
    CFG_BASE0 = 2'd0,
    CFG_BASE1 = 2'd1,
    CFG_MODE  = 2'd2
  } cfg_reg_e;
endpackage

// File: rtl/cx_cfg.sv
module cx_cfg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [15:0]   wdata,
  output logic [AW-1:0] base0,
  output logic [AW-1:0] base1,
  output logic [3:0]    ptr_w,
  output logic [3:0]    len_code,
  output logic          bank_sel
);
  import cx_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base0    <= '0;
      base1    <= '0;
      ptr_w    <= 4'(PTR_MIN);
      len_code <= LEN_FULL;
      bank_sel <= 1'b0;
    end else if (we) begin
      case (addr)
        CFG_BASE0: base0 <= wdata[AW-1:0];
        CFG_BASE1: base1 <= wdata[AW-1:0];
        CFG_MODE: begin
          ptr_w    <= wdata[3:0];
          len_code <= wdata[7:4];
          bank_sel <= wdata[8];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cx_field_parse.sv
module cx_field_parse
  import cx_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  input  logic [3:0]         ptr_w,
  input  logic [3:0]         len_code,
  output logic [PTR_MAX-1:0] ptr,
  output logic [HALF_W-1:0]  upper,
  output logic               code_ok
);
  logic [BODY_W-1:0] body, after_ptr, ptr_sh;
  logic [3:0]        w_eff;

  always_comb begin
    if (ptr_w < 4'(PTR_MIN))      w_eff = 4'(PTR_MIN);
    else if (ptr_w > 4'(PTR_MAX)) w_eff = 4'(PTR_MAX);
    else                          w_eff = ptr_w;
  end

  assign body      = word[BODY_W-1:0];
  assign ptr_sh    = body >> (BODY_W - int'(w_eff));
  assign ptr       = ptr_sh[PTR_MAX-1:0];
  assign after_ptr = body << w_eff;

  always_comb begin
    code_ok = 1'b1;
    case (len_code)
      LEN_FULL: upper = after_ptr[BODY_W-1 -: HALF_W];
      LEN_15:   upper = {after_ptr[BODY_W-1], after_ptr[BODY_W-1 -: 15]};
      LEN_10:   upper = {{(HALF_W-10){after_ptr[BODY_W-1]}}, after_ptr[BODY_W-1 -: 10]};
      LEN_NONE: upper = '0;
      default: begin
        upper   = '0;
        code_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cx_vocab.sv
module cx_vocab #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int NBANK = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NBANK)-1:0] wbank,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(NBANK)-1:0] rbank,
  input  logic [AW-1:0]            raddr,
  output logic [DW-1:0]            rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (int'(wbank) == b)) mem[waddr] <= wdata;
    end
    assign bank_rd[b] = mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= bank_rd[rbank];
  end
endmodule

// File: rtl/cinstr_expand.sv
module cinstr_expand
  import cx_pkg::*;
#(
  parameter int VOC_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              voc_we,
  input  logic              voc_bank,
  input  logic [VOC_AW-1:0] voc_addr,
  input  logic [15:0]       voc_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              err_pulse
);
  logic [VOC_AW-1:0]  base0, base1, rd_addr;
  logic [3:0]         ptr_w, len_code;
  logic               bank_sel, code_ok, accept;
  logic [PTR_MAX-1:0] ptr;
  logic [HALF_W-1:0]  upper_d, upper_q, lower_q;

  cx_cfg #(.AW(VOC_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .base0(base0), .base1(base1), .ptr_w(ptr_w), .len_code(len_code),
    .bank_sel(bank_sel)
  );

  cx_field_parse u_parse (
    .word(in_data), .ptr_w(ptr_w), .len_code(len_code),
    .ptr(ptr), .upper(upper_d), .code_ok(code_ok)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign rd_addr  = (bank_sel ? base1 : base0) + VOC_AW'(ptr);

  cx_vocab #(.AW(VOC_AW), .DW(HALF_W), .NBANK(2)) u_vocab (
    .clk(clk), .we(voc_we), .wbank(voc_bank), .waddr(voc_addr), .wdata(voc_wdata),
    .re(accept && code_ok), .rbank(bank_sel), .raddr(rd_addr), .rdata(lower_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err_pulse <= 1'b0;
      upper_q   <= '0;
    end else begin
      err_pulse <= accept && !code_ok;
      if (accept) begin
        out_valid <= code_ok;
        upper_q   <= upper_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_data = {upper_q, lower_q};
endmodule

// File: rtl/cx_checker.sv
module cx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        err_pulse
);
  a_r8_err_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !out_valid);

  a_r9_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid != err_pulse));

  a_r9_valid_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind cinstr_expand cx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .err_pulse(err_pulse)
);

// File: tb/cinstr_expand_bench.sv
module cinstr_expand_bench;
  localparam int AW = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, voc_we = 0, voc_bank = 0, in_valid = 0, out_ready = 1;
  logic [1:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, voc_wdata = 0;
  logic [AW-1:0] voc_addr = 0;
  logic [31:0] in_data = 0;
  logic in_ready, out_valid, err_pulse;
  logic [31:0] out_data;

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit bp_on = 0;

  always #2 clk = ~clk;

  cinstr_expand #(.VOC_AW(AW)) u_cinstr_expand (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .voc_we(voc_we), .voc_bank(voc_bank),
    .voc_addr(voc_addr), .voc_wdata(voc_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err_pulse(err_pulse)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_ram [2][DEPTH];
  int m_base [2];
  int m_w, m_code, m_sel;
  bit mv, me;
  logic [31:0] md;

  function automatic void model_decode(input logic [31:0] w, output bit ok,
                                       output logic [31:0] res);
    int wd, len, pos, p, byp, addr;
    wd = (m_w < 2) ? 2 : (m_w > 9) ? 9 : m_w;
    ok = 1;
    case (m_code)
      11: len = 0;
      12: len = 10;
      13: len = 15;
      14: len = 16;
      default: begin len = 0; ok = 0; end
    endcase
    pos = 27; p = 0; byp = 0;
    for (int i = 0; i < wd; i++) begin p = p * 2 + int'(w[pos]); pos--; end
    for (int i = 0; i < len; i++) begin byp = byp * 2 + int'(w[pos]); pos--; end
    if (len > 0 && len < 16 && byp >= (1 << (len - 1))) byp -= (1 << len);
    addr = (m_base[m_sel] + p) % DEPTH;
    res = {byp[15:0], m_ram[m_sel][addr]};
  endfunction

  always @(posedge clk) begin
    bit ok, rdy;
    logic [31:0] r;
    if (!rst_n) begin
      mv <= 0; me <= 0;
      m_base[0] = 0; m_base[1] = 0; m_w = 2; m_code = 14; m_sel = 0;
    end else begin
      rdy = !mv || out_ready;
      if (in_valid && rdy) begin
        model_decode(in_data, ok, r);
        me <= !ok;
        mv <= ok;
        if (ok) md <= r;
      end else begin
        me <= 0;
        if (out_ready) mv <= 0;
      end
      if (voc_we) m_ram[voc_bank][voc_addr] = voc_wdata;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_base[0] = int'(cfg_wdata[AW-1:0]);
          2'd1: m_base[1] = int'(cfg_wdata[AW-1:0]);
          2'd2: begin
            m_w = int'(cfg_wdata[3:0]); m_code = int'(cfg_wdata[7:4]);
            m_sel = int'(cfg_wdata[8]);
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- comparison each cycle ----------------
  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    check(rst_n ? "R10" : "R1", 32'(in_ready), 32'(!mv || out_ready));
    check(rst_n ? "R9" : "R1", 32'(out_valid), 32'(mv));
    check(rst_n ? "R8" : "R1", 32'(err_pulse), 32'(me));
    if (mv && rst_n) check(cur_req, out_data, md);
  end

  always @(posedge clk) begin
    #1 out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
  end

  // ---------------- stimulus ----------------
  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic set_mode(input int w, input int code, input int sel);
    cfg_write(2'd2, 16'((sel << 8) | (code << 4) | w));
  endtask

  function automatic logic [31:0] mk(input int w, input int p, input int len, input int byp);
    logic [31:0] v;
    int pos;
    v = {4'($urandom), 28'($urandom)};
    pos = 27;
    for (int i = w - 1; i >= 0; i--) begin v[pos] = 1'((p >> i) & 1); pos--; end
    for (int i = len - 1; i >= 0; i--) begin v[pos] = 1'((byp >> i) & 1); pos--; end
    return v;
  endfunction

  task automatic send(input logic [31:0] w);
    bit ok;
    in_valid = 1; in_data = w;
    forever begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 0;
  endtask

  task automatic drain();
    bp_on = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic burst(input string req, input int n, input int w, input int len,
                       input int pmax_w);
    cur_req = req;
    for (int i = 0; i < n; i++)
      send(mk(w, int'($urandom % (1 << pmax_w)), len, int'($urandom % 65536)));
    drain();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: load both banks with distinct contents
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) begin
        @(posedge clk); #1;
        voc_we = 1; voc_bank = 1'(b); voc_addr = AW'(a);
        voc_wdata = 16'((b ? 16'hB000 : 16'hA000) ^ (a * 16'd37));
      end
    @(posedge clk); #1 voc_we = 0;
    cfg_write(2'd0, 16'd5);
    cfg_write(2'd1, 16'd100);
    cfg_write(2'd3, 16'hFFFF);               // R4: unused address
    // R2 R3 R5: full bypass, bank 0
    set_mode(4, 14, 0);
    burst("R5", 20, 4, 16, 4);
    // R4 R6: bank 1, 15- and 10-bit bypass, wrap past end of bank
    set_mode(9, 13, 1);
    burst("R6", 20, 9, 15, 9);
    set_mode(7, 12, 1);
    burst("R6", 20, 7, 10, 7);
    // R7: empty bypass
    set_mode(2, 11, 0);
    burst("R7", 12, 2, 0, 2);
    // R2: width clamps
    set_mode(0, 14, 1);
    burst("R2", 10, 2, 16, 2);
    set_mode(15, 12, 0);
    burst("R2", 10, 9, 10, 9);
    // R8: illegal codes
    set_mode(5, 3, 0);
    burst("R8", 6, 5, 0, 5);
    set_mode(5, 15, 1);
    burst("R8", 6, 5, 0, 5);
    // R9 R10: back-to-back under random stalls
    set_mode(6, 13, 0);
    bp_on = 1;
    cur_req = "R10";
    for (int i = 0; i < 300; i++)
      send(mk(6, int'($urandom % 64), 15, int'($urandom % 32768)));
    drain();
    // R3: rewrite a vocabulary word, then read it
    set_mode(3, 14, 0);
    @(posedge clk); #1;
    voc_we = 1; voc_bank = 0; voc_addr = AW'(7); voc_wdata = 16'h5A3C;
    @(posedge clk); #1 voc_we = 0;
    cur_req = "R3";
    send(mk(3, 2, 16, 16'h8001));
    drain();
    // R1: reset mid-run
    rst_n = 0;
    cur_req = "R1";
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule